// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This core fetches, decodes and retires one 32-bit instruction in every clock cycle. Its instruction set has seven instructions: register add and subtract (plus register AND, OR and signed less-than, decoded from the same register-register group), OR with a zero-extended immediate, word load, word store, branch on equal, and absolute jump. The core holds the program counter, the next-address selection, a 32 x 32 register file, the immediate extender, the ALU and a two-level decoder. A main decoder turns the opcode into datapath controls and a 3-bit ALU group code. A small local decoder combines that group code with the function field to pick the ALU operation.

Instructions are read through a combinational fetch port addressed by the PC. Data memory is reached through an address, write-data and write-enable port, with a combinational read-data return. The memory itself lives outside the core and is written on the clock edge. A debug port shows the PC of the instruction in flight together with its register write (enable, index and value), so that an instruction-level model can check every retired instruction.

Top module: `uniclock_cpu`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0 and clears every register to 0 on the clock edge where it is sampled high.
- R2: An opcode of 000000 writes register rd (bits 15:11) with rs op rt. Funct 100000 gives the sum, 100010 gives rs minus rt, 100100 gives the bitwise AND and 100101 gives the bitwise OR.
- R3: An opcode of 000000 with funct 101010 writes rd with 1 if rs is less than rt as signed values, and with 0 otherwise.
- R4: Opcode 001101 writes register rt (bits 20:16) with rs OR the zero-extended 16-bit immediate (bits 15:0).
- R5: Opcode 100011 drives the data address rs + sign-extended immediate and writes the returned data word into rt.
- R6: Opcode 101011 drives the data address rs + sign-extended immediate with write data rt and the data write enable high. It writes no register.
- R7: Opcode 000100 compares rs and rt by subtraction. If they are equal, the next PC is PC+4+(sign-extended immediate shifted left by 2). Otherwise it is PC+4. It writes neither a register nor memory.
- R8: Opcode 000010 sets the next PC to {upper 4 bits of PC+4, bits 25:0 of the instruction, 2'b00}. It writes neither a register nor memory.
- R9: Register 0 always reads as 0, and a write that names register 0 leaves it unchanged.
- R10: Every instruction other than a taken branch or a jump advances the PC by 4. Each instruction completes in one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction to fetch (the PC) |
| imem_rdata | input | 32 | Instruction word returned combinationally |
| dmem_addr | output | 32 | Data byte address (ALU result) |
| dmem_wdata | output | 32 | Store data (register rt) |
| dmem_we | output | 1 | Data write enable, taken at the next rising edge |
| dmem_rdata | input | 32 | Load data returned combinationally |
| dbg_pc | output | 32 | PC of the instruction being executed this cycle |
| dbg_wen | output | 1 | The current instruction writes a register |
| dbg_waddr | output | 5 | Destination register index |
| dbg_wdata | output | 32 | Value written to the destination register |

## Verification
On every cycle the assertions check how the PC moves: it returns to zero after reset, steps by four on sequential instructions, reaches the computed target after a taken branch, and reaches the page-relative target after a jump. They also check that register 0 reads back as zero and that a branch always selects subtraction. The data results cannot be seen by a property that only knows the current cycle: the values written by arithmetic, signed comparison, zero and sign extension, and a load after a store to the same word. These come from the bench's scenarios, which run directed programs and random programs against an instruction-level model.

// File: rtl/ucpu_pkg.sv
package ucpu_pkg;

  localparam int XLEN   = 32;
  localparam int NREGS  = 32;
  localparam int RIDX_W = $clog2(NREGS);
  localparam int IMM_W  = 16;
  localparam int TGT_W  = 26;

  // major opcodes
  localparam logic [5:0] OPC_REG  = 6'b000000;
  localparam logic [5:0] OPC_ORI  = 6'b001101;
  localparam logic [5:0] OPC_LOAD = 6'b100011;
  localparam logic [5:0] OPC_STOR = 6'b101011;
  localparam logic [5:0] OPC_BEQ  = 6'b000100;
  localparam logic [5:0] OPC_JMP  = 6'b000010;

  // ALU group codes from the main decoder
  localparam logic [2:0] GRP_ADD = 3'b000;
  localparam logic [2:0] GRP_SUB = 3'b001;
  localparam logic [2:0] GRP_OR  = 3'b010;
  localparam logic [2:0] GRP_FN  = 3'b100;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_sel_e;

  typedef struct packed {
    logic       dst_is_rd;
    logic       b_is_imm;
    logic       wb_is_mem;
    logic       rf_we;
    logic       dm_we;
    logic       is_branch;
    logic       is_jump;
    logic       imm_signed;
    logic [2:0] alu_grp;
  } ctrl_t;

  function automatic logic [XLEN-1:0] widen_imm(input logic [IMM_W-1:0] imm,
                                                input logic signed_ext);
    logic fill;
    fill = signed_ext & imm[IMM_W-1];
    return {{(XLEN-IMM_W){fill}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] seq_pc,
                                                  input logic [IMM_W-1:0] imm);
    return seq_pc + {widen_imm(imm, 1'b1), 2'b00}[XLEN-1:0];
  endfunction

  function automatic logic [XLEN-1:0] jump_dest(input logic [XLEN-1:0] seq_pc,
                                                input logic [TGT_W-1:0] tgt);
    return {seq_pc[XLEN-1:TGT_W+2], tgt, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_sel_e sel,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    case (sel)
      ALU_AND: r = a & b;
      ALU_OR:  r = a | b;
      ALU_SUB: r = a - b;
      ALU_SLT: r = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: r = a + b;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ucpu_main_dec.sv
module ucpu_main_dec
  import ucpu_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctl
);
  always_comb begin
    ctl = '0;
    case (opcode)
      OPC_REG: begin
        ctl.dst_is_rd = 1'b1;
        ctl.rf_we     = 1'b1;
        ctl.alu_grp   = GRP_FN;
      end
      OPC_ORI: begin
        ctl.b_is_imm  = 1'b1;
        ctl.rf_we     = 1'b1;
        ctl.alu_grp   = GRP_OR;
      end
      OPC_LOAD: begin
        ctl.b_is_imm   = 1'b1;
        ctl.wb_is_mem  = 1'b1;
        ctl.rf_we      = 1'b1;
        ctl.imm_signed = 1'b1;
        ctl.alu_grp    = GRP_ADD;
      end
      OPC_STOR: begin
        ctl.b_is_imm   = 1'b1;
        ctl.dm_we      = 1'b1;
        ctl.imm_signed = 1'b1;
        ctl.alu_grp    = GRP_ADD;
      end
      OPC_BEQ: begin
        ctl.is_branch = 1'b1;
        ctl.alu_grp   = GRP_SUB;
      end
      OPC_JMP: begin
        ctl.is_jump   = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/ucpu_alu_ctl.sv
module ucpu_alu_ctl
  import ucpu_pkg::*;
(
  input  logic [2:0] grp,
  input  logic [5:0] funct,
  output alu_sel_e   sel
);
  always_comb begin
    if (grp[2]) begin
      case (funct[3:0])
        4'b0010: sel = ALU_SUB;
        4'b0100: sel = ALU_AND;
        4'b0101: sel = ALU_OR;
        4'b1010: sel = ALU_SLT;
        default: sel = ALU_ADD;
      endcase
    end else begin
      case (grp[1:0])
        2'b10:   sel = ALU_OR;
        2'b01:   sel = ALU_SUB;
        default: sel = ALU_ADD;
      endcase
    end
  end
endmodule

// File: rtl/ucpu_regfile.sv
module ucpu_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [DEPTH];
  logic         wr_hit;

  assign wr_hit = we && (wa != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (wr_hit) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];

  AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ra_a == '0) |-> (rd_a == '0)); // R9
  AST_R0_READS_ZERO_B: assert property (@(posedge clk) disable iff (rst)
    (ra_b == '0) |-> (rd_b == '0)); // R9
endmodule

// File: rtl/uniclock_cpu.sv
module uniclock_cpu
  import ucpu_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic [XLEN-1:0] dbg_pc,
  output logic            dbg_wen,
  output logic [RIDX_W-1:0] dbg_waddr,
  output logic [XLEN-1:0] dbg_wdata
);
  logic [XLEN-1:0]   pc, pc_seq, pc_next, br_dest, jmp_dest;
  logic [5:0]        f_op, f_fn;
  logic [RIDX_W-1:0] f_rs, f_rt, f_rd, wr_idx;
  logic [IMM_W-1:0]  f_imm;
  logic [TGT_W-1:0]  f_tgt;
  ctrl_t             ctl;
  alu_sel_e          alu_sel;
  logic [XLEN-1:0]   rs_val, rt_val, imm_ext, opnd_b, alu_y, wb_val;
  logic              alu_zero, br_taken;

  // instruction fields
  assign f_op  = imem_rdata[31:26];
  assign f_rs  = imem_rdata[25:21];
  assign f_rt  = imem_rdata[20:16];
  assign f_rd  = imem_rdata[15:11];
  assign f_fn  = imem_rdata[5:0];
  assign f_imm = imem_rdata[15:0];
  assign f_tgt = imem_rdata[25:0];

  ucpu_main_dec u_dec (.opcode(f_op), .ctl(ctl));
  ucpu_alu_ctl  u_actl (.grp(ctl.alu_grp), .funct(f_fn), .sel(alu_sel));

  ucpu_regfile #(.W(XLEN), .DEPTH(NREGS)) u_rf (
    .clk (clk),
    .rst (rst),
    .ra_a(f_rs),
    .ra_b(f_rt),
    .rd_a(rs_val),
    .rd_b(rt_val),
    .we  (ctl.rf_we),
    .wa  (wr_idx),
    .wd  (wb_val)
  );

  // execute
  assign imm_ext  = widen_imm(f_imm, ctl.imm_signed);
  assign opnd_b   = ctl.b_is_imm ? imm_ext : rt_val;
  assign alu_y    = alu_eval(alu_sel, rs_val, opnd_b);
  assign alu_zero = (alu_y == '0);

  // write back
  assign wr_idx = ctl.dst_is_rd ? f_rd : f_rt;
  assign wb_val = ctl.wb_is_mem ? dmem_rdata : alu_y;

  // next address
  assign pc_seq   = pc + XLEN'(4);
  assign br_dest  = branch_dest(pc_seq, f_imm);
  assign jmp_dest = jump_dest(pc_seq, f_tgt);
  assign br_taken = ctl.is_branch & alu_zero;

  always_comb begin
    if (ctl.is_jump)    pc_next = jmp_dest;
    else if (br_taken)  pc_next = br_dest;
    else                pc_next = pc_seq;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  // ports
  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctl.dm_we;
  assign dbg_pc     = pc;
  assign dbg_wen    = ctl.rf_we;
  assign dbg_waddr  = wr_idx;
  assign dbg_wdata  = wb_val;

  // assertions
  AST_RESET_PC: assert property (@(posedge clk)
    rst |=> (pc == '0)); // R1
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (!ctl.is_jump && !br_taken) |=> (pc == $past(pc) + XLEN'(4))); // R10
  AST_BRANCH_DEST: assert property (@(posedge clk) disable iff (rst)
    (br_taken && !ctl.is_jump) |=>
      (pc == $past(pc) + XLEN'(4) + {{(XLEN-IMM_W-2){$past(f_imm[IMM_W-1])}}, $past(f_imm), 2'b00})); // R7
  AST_JUMP_DEST: assert property (@(posedge clk) disable iff (rst)
    ctl.is_jump |=> (pc[1:0] == 2'b00 && pc[TGT_W+1:2] == $past(f_tgt))); // R8
  AST_BEQ_SUBTRACTS: assert property (@(posedge clk) disable iff (rst)
    ctl.is_branch |-> (alu_sel == ALU_SUB)); // R7
  AST_STORE_NO_RF: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> !dbg_wen); // R6
endmodule

// File: tb/uniclock_cpu_tb_top.sv
module uniclock_cpu_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dbg_wen;
  logic [31:0] dbg_pc, dbg_wdata;
  logic [4:0]  dbg_waddr;

  logic [31:0] imem [256];
  logic [31:0] dmem [256];

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model state
  logic [31:0] m_pc;
  logic [31:0] m_rf [32];
  logic [31:0] m_dm [256];

  always #10ns clk = ~clk;

  uniclock_cpu dut_i (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata),
    .dbg_pc(dbg_pc), .dbg_wen(dbg_wen), .dbg_waddr(dbg_waddr), .dbg_wdata(dbg_wdata)
  );

  assign imem_rdata = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b00000, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(input int tgt);
    return {6'b000010, 26'(tgt)};
  endfunction

  function automatic logic [31:0] rand_instr(input int idx);
    int k, rs, rt, rd;
    logic [15:0] imm;
    k = int'($urandom % 10); rs = int'($urandom % 8); rt = int'($urandom % 8);
    rd = int'($urandom % 8); imm = 16'($urandom);
    case (k)
      0: return enc_r(rs, rt, rd, 6'b100000);
      1: return enc_r(rs, rt, rd, 6'b100010);
      2: return enc_r(rs, rt, rd, 6'b100100);
      3: return enc_r(rs, rt, rd, 6'b100101);
      4: return enc_r(rs, rt, rd, 6'b101010);
      5: return enc_i(6'b001101, rs, rt, imm);
      6: return enc_i(6'b100011, rs, rt, imm);
      7: return enc_i(6'b101011, rs, rt, imm);
      8: return enc_i(6'b000100, rs, rt, 16'($urandom % 6));
      default: begin
        int t;
        t = int'($urandom % 256);
        if (t == idx) t = (t + 1) % 256;
        return enc_j(t);
      end
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (pc %h)", tag, act, exp, dbg_pc);
    end
  endtask

  task automatic reset_dut();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_pc = 32'h0;
    for (int i = 0; i < 32; i++) m_rf[i] = 32'h0;
    for (int i = 0; i < 256; i++) m_dm[i] = dmem[i];
    chk("R1 pc after reset", dbg_pc, 32'h0);
  endtask

  // compare one instruction against the model, then advance one cycle
  task automatic step();
    logic [31:0] ins, a, b, sx, wd, ma, md, npc;
    logic [5:0]  op, fn;
    logic [4:0]  wa;
    logic        wen, mwe;
    string       tag;
    ins = imem[m_pc[9:2]];
    op = ins[31:26]; fn = ins[5:0];
    a = m_rf[ins[25:21]]; b = m_rf[ins[20:16]];
    sx = {{16{ins[15]}}, ins[15:0]};
    wen = 1'b0; mwe = 1'b0; wa = 5'd0; wd = 32'h0; ma = 32'h0; md = 32'h0;
    npc = m_pc + 32'd4; tag = "R10";
    case (op)
      6'b000000: begin
        wen = 1'b1; wa = ins[15:11]; tag = "R2";
        case (fn)
          6'b100000: wd = a + b;
          6'b100010: wd = a + ~b + 32'd1;
          6'b100100: wd = a & b;
          6'b100101: wd = a | b;
          6'b101010: begin tag = "R3"; wd = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; end
          default:   wd = a + b;
        endcase
      end
      6'b001101: begin wen = 1'b1; wa = ins[20:16]; wd = a | {16'h0, ins[15:0]}; tag = "R4"; end
      6'b100011: begin wen = 1'b1; wa = ins[20:16]; ma = a + sx; wd = m_dm[ma[9:2]]; tag = "R5"; end
      6'b101011: begin mwe = 1'b1; ma = a + sx; md = b; tag = "R6"; end
      6'b000100: begin tag = "R7"; if (a == b) npc = m_pc + 32'd4 + (sx << 2); end
      6'b000010: begin tag = "R8"; npc = {npc[31:28], ins[25:0], 2'b00}; end
      default: ;
    endcase
    chk("R10 pc", dbg_pc, m_pc);
    chk({tag, " wen"}, {31'h0, dbg_wen}, {31'h0, wen});
    if (wen) begin
      chk({tag, " waddr"}, {27'h0, dbg_waddr}, {27'h0, wa});
      chk((wa == 5'd0) ? "R9 wdata" : {tag, " wdata"}, dbg_wdata, wd);
    end
    chk({tag, " dmem_we"}, {31'h0, dmem_we}, {31'h0, mwe});
    if (mwe) begin
      chk({tag, " dmem_addr"}, dmem_addr, ma);
      chk({tag, " dmem_wdata"}, dmem_wdata, md);
    end
    if (wen && wa != 5'd0) m_rf[wa] = wd;
    if (mwe) m_dm[ma[9:2]] = md;
    m_pc = npc;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    // ---------------- directed program ----------------
    for (int i = 0; i < 256; i++) begin
      imem[i] = enc_i(6'b001101, 7, 7, 16'h0001);
      dmem[i] = 32'h1000_0000 + 32'(i);
    end
    dmem[255] = 32'hDEAD_BEEF;
    imem[0]  = enc_i(6'b001101, 0, 1, 16'h8001);
    imem[1]  = enc_i(6'b100011, 3, 2, 16'hFFFC);
    imem[2]  = enc_r(0, 1, 3, 6'b100010);
    imem[3]  = enc_r(3, 1, 4, 6'b101010);
    imem[4]  = enc_r(1, 3, 5, 6'b101010);
    imem[5]  = enc_i(6'b101011, 1, 2, 16'h0008);
    imem[6]  = enc_i(6'b001101, 0, 0, 16'h0055);
    imem[7]  = enc_r(0, 1, 6, 6'b100000);
    imem[8]  = enc_i(6'b000100, 1, 6, 16'h0002);
    imem[11] = enc_i(6'b000100, 1, 2, 16'h0005);
    imem[12] = enc_j(20);
    imem[20] = enc_r(1, 2, 8, 6'b100100);
    imem[21] = enc_r(1, 3, 9, 6'b100101);
    imem[22] = enc_i(6'b100011, 1, 10, 16'h0008);

    reset_dut();
    chk("R4 ori zero-extends", dbg_wdata, 32'h0000_8001);          step();
    chk("R10 pc plus 4", dbg_pc, 32'h4);
    chk("R5 load sign-ext offset", dbg_wdata, 32'hDEAD_BEEF);      step();
    chk("R2 sub", dbg_wdata, 32'hFFFF_7FFF);                       step();
    chk("R3 slt neg<pos", dbg_wdata, 32'h1);                       step();
    chk("R3 slt pos<neg", dbg_wdata, 32'h0);                       step();
    chk("R6 store we", {31'h0, dmem_we}, 32'h1);
    chk("R6 store addr", dmem_addr, 32'h0000_8009);
    chk("R6 store no rf write", {31'h0, dbg_wen}, 32'h0);          step();
    step();
    chk("R9 r0 stays zero", dbg_wdata, 32'h0000_8001);             step();
    step();
    chk("R7 branch taken", dbg_pc, 32'd44);
    step();
    chk("R7 branch not taken", dbg_pc, 32'd48);
    step();
    chk("R8 jump target", dbg_pc, 32'd80);
    chk("R2 and", dbg_wdata, 32'h0000_8001);                       step();
    chk("R2 or", dbg_wdata, 32'hFFFF_FFFF);                        step();
    chk("R5 load after store", dbg_wdata, 32'hDEAD_BEEF);          step();
    for (int i = 0; i < 20; i++) step();

    // ---------------- random programs ----------------
    for (int ep = 0; ep < 8; ep++) begin
      for (int i = 0; i < 256; i++) begin
        imem[i] = rand_instr(i);
        dmem[i] = $urandom;
      end
      for (int i = 0; i < 8; i++) imem[i] = enc_i(6'b001101, 0, i, 16'($urandom));
      reset_dut();
      for (int c = 0; c < 400; c++) step();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20ns * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule